// File: doc/BRIEF.md
# SPI Master with Timed Select

This block is a single-master serial peripheral controller that runs entirely on the system clock. A host asks for a transfer by pulsing a start input together with a transmit word, a target select index, the clock polarity, the clock phase and a half-period divider. The block then pulls one of two active-low select lines low. It waits a fixed lead time, drives the serial clock for one word and shifts data out most significant bit first. It samples the returning serial data and holds the select low for a fixed lag after the final clock edge. It then releases the select and reports the received word with a one-cycle done pulse. A minimum idle gap follows before the next request can be taken.

All timing is counted in system clocks. The lead, the lag and the idle gap are each a timed state of the controller. Every serial clock half-phase lasts the divider value, and divider values below 2 count as 2. The controller state machine has five named states:
- `ST_IDLE`: waiting for a start request.
- `ST_LEAD`: select asserted, no clock edge yet.
- `ST_RUN`: clock edges being generated.
- `ST_LAG`: final edge done, select still asserted.
- `ST_GAP`: select released, new requests not yet accepted.

The transitions are `ST_IDLE`→`ST_LEAD` on an accepted start, `ST_LEAD`→`ST_RUN` when the lead count expires (first edge), `ST_RUN`→`ST_LAG` on the last edge, `ST_LAG`→`ST_GAP` when the lag count expires (deselect and done), and `ST_GAP`→`ST_IDLE` when the gap count expires.

Top module: `spi_tsel_master`

## Requirements
- R1: During reset, `ss_n_o` is 2'b11, `done_o` is 0, `mosi_o` is 0 and `sck_o` equals the `cpol_i` level.
- R2: While no transfer is in progress, `sck_o` rests at the `cpol_i` level: low for 0, high for 1.
- R3: Each transfer has exactly 2×WORD_W serial clock edges. Every high and every low phase between edges lasts H system clocks, where H is `div_i` captured at start, or 2 when `div_i` is below 2.
- R4: The first serial clock edge appears exactly LEAD_CYC (default 2) system clocks after the select goes low.
- R5: The select goes high exactly LAG_CYC (default 2) system clocks after the last serial clock edge.
- R6: When a new start is already pending, the select stays high for exactly GAP_CYC+1 (default 3) system clocks between two transfers.
- R7: Data moves most significant bit first. With `cpha_i`=0, `mosi_o` shows the MSB when the select falls, and `miso_i` is sampled on odd-numbered edges (1st, 3rd, …). With `cpha_i`=1, `mosi_o` changes on odd-numbered edges and `miso_i` is sampled on even-numbered edges.
- R8: `sel_idx_i`=0 drives `ss_n_o` to 2'b10 and `sel_idx_i`=1 drives it to 2'b01. At most one select is ever low.
- R9: `done_o` is high for one system clock, in the same cycle that the select returns high. `rx_word_o` carries the received word from that cycle on.
- R10: A start request that arrives while a transfer, its lag or its gap is in progress is ignored. It produces no extra select, edge or done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Transfer request, taken only in ST_IDLE |
| tx_word_i | input | WORD_W | Word to transmit |
| sel_idx_i | input | 1 | Which select line to assert |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | Clock phase: 0 samples on odd edges, 1 on even edges |
| div_i | input | DIV_W | Half-period in system clocks (minimum 2) |
| miso_i | input | 1 | Serial data from the slave |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| ss_n_o | output | 2 | Active-low slave selects |
| rx_word_o | output | WORD_W | Last received word |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions rely on the mode, divider and select index being captured in the cycle a start is accepted. They also assume that `miso_i` is stable whenever the controller generates a sampling edge, and that the lead, lag and gap parameters are at least 2. The bench's slave model changes `miso_i` only in the half of the system clock that follows a serial clock edge it has observed, which keeps it well away from the next sampling edge. The bench changes host inputs only at falling system clock edges, one cycle before a start is taken.

// File: rtl/spi_tsel_pkg.sv
package spi_tsel_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_RUN,
        ST_LAG,
        ST_GAP
    } spi_st_e;
endpackage

// File: rtl/spi_tsel_timer.sv
module spi_tsel_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             tc_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end

    assign tc_o = (cnt_q == lim_i - 1'b1);
endmodule

// File: rtl/spi_tsel_shift.sv
module spi_tsel_shift #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              cpha_i,
    input  logic [WORD_W-1:0] tx_i,
    input  logic              launch_i,
    input  logic              sample_i,
    input  logic              miso_i,
    output logic              mosi_o,
    output logic [WORD_W-1:0] rx_o
);
    logic [WORD_W-1:0] tx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            mosi_o <= 1'b0;
            rx_o   <= '0;
        end else if (load_i) begin
            rx_o <= '0;
            if (cpha_i) begin
                tx_sh  <= tx_i;
                mosi_o <= 1'b0;
            end else begin
                tx_sh  <= tx_i << 1;
                mosi_o <= tx_i[WORD_W-1];
            end
        end else begin
            if (launch_i) begin
                mosi_o <= tx_sh[WORD_W-1];
                tx_sh  <= tx_sh << 1;
            end
            if (sample_i) rx_o <= {rx_o[WORD_W-2:0], miso_i};
        end
    end

    // R7: the controller never asks for a load and a bit move together
    load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !(launch_i || sample_i));
endmodule

// File: rtl/spi_tsel_master.sv
module spi_tsel_master
    import spi_tsel_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int DIV_W    = 8,
    parameter int LEAD_CYC = 2,
    parameter int LAG_CYC  = 2,
    parameter int GAP_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] tx_word_i,
    input  logic              sel_idx_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              miso_i,
    output logic              sck_o,
    output logic              mosi_o,
    output logic [1:0]        ss_n_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              done_o
);
    localparam int EDGES = 2 * WORD_W;
    localparam int EC_W  = $clog2(EDGES + 1);
    localparam logic [DIV_W-1:0] HALF_MIN = DIV_W'(2);

    spi_st_e          state, state_nxt;
    logic             cpol_q, cpha_q, sck_act, done_r;
    logic [DIV_W-1:0] half_q, lim;
    logic [EC_W-1:0]  edge_cnt, nxt_edge;
    logic [1:0]       ss_n_r;
    logic [WORD_W-1:0] rx_sh, rx_word_r;
    logic             go, tc, tog, launch, sample;

    assign go       = (state == ST_IDLE) && start_i;
    assign nxt_edge = edge_cnt + 1'b1;
    assign tog      = ((state == ST_LEAD) || (state == ST_RUN)) && tc;
    assign launch   = tog && (cpha_q ? nxt_edge[0]
                                     : (!nxt_edge[0] && (nxt_edge != EC_W'(EDGES))));
    assign sample   = tog && (cpha_q ? !nxt_edge[0] : nxt_edge[0]);

    always_comb begin
        unique case (state)
            ST_LEAD: lim = DIV_W'(LEAD_CYC);
            ST_RUN:  lim = half_q;
            ST_LAG:  lim = DIV_W'(LAG_CYC);
            ST_GAP:  lim = DIV_W'(GAP_CYC);
            default: lim = HALF_MIN;
        endcase
    end

    spi_tsel_timer #(.CNT_W(DIV_W)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tc || go),
        .lim_i (lim),
        .tc_o  (tc)
    );

    spi_tsel_shift #(.WORD_W(WORD_W)) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (go),
        .cpha_i   (cpha_i),
        .tx_i     (tx_word_i),
        .launch_i (launch),
        .sample_i (sample),
        .miso_i   (miso_i),
        .mosi_o   (mosi_o),
        .rx_o     (rx_sh)
    );

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (go) state_nxt = ST_LEAD;
            ST_LEAD: if (tc) state_nxt = ST_RUN;
            ST_RUN:  if (tc && nxt_edge == EC_W'(EDGES)) state_nxt = ST_LAG;
            ST_LAG:  if (tc) state_nxt = ST_GAP;
            ST_GAP:  if (tc) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // registered outputs and transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpol_q    <= 1'b0;
            cpha_q    <= 1'b0;
            half_q    <= HALF_MIN;
            edge_cnt  <= '0;
            sck_act   <= 1'b0;
            ss_n_r    <= 2'b11;
            done_r    <= 1'b0;
            rx_word_r <= '0;
        end else begin
            done_r <= 1'b0;
            unique case (state)
                ST_IDLE: if (go) begin
                    cpol_q   <= cpol_i;
                    cpha_q   <= cpha_i;
                    half_q   <= (div_i < HALF_MIN) ? HALF_MIN : div_i;
                    edge_cnt <= '0;
                    ss_n_r   <= sel_idx_i ? 2'b01 : 2'b10;
                end
                ST_LEAD, ST_RUN: if (tc) begin
                    sck_act  <= ~sck_act;
                    edge_cnt <= nxt_edge;
                end
                ST_LAG: if (tc) begin
                    ss_n_r    <= 2'b11;
                    done_r    <= 1'b1;
                    rx_word_r <= rx_sh;
                end
                default: begin end
            endcase
        end
    end

    assign sck_o     = ((state == ST_IDLE) ? cpol_i : cpol_q) ^ sck_act;
    assign ss_n_o    = ss_n_r;
    assign done_o    = done_r;
    assign rx_word_o = rx_word_r;

    // checker state: cycles since last clock toggle and since select fell
    logic [1:0] since_tog, since_sel;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_tog <= '0;
            since_sel <= '0;
        end else begin
            since_tog <= tog ? 2'd0 : ((since_tog == 2'd3) ? since_tog : since_tog + 2'd1);
            since_sel <= (ss_n_r == 2'b11) ? 2'd0
                       : ((since_sel == 2'd3) ? since_sel : since_sel + 2'd1);
        end
    end

    // R8
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ss_n_r));
    // R9
    done_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_r |-> (ss_n_r == 2'b11));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_r |=> !done_r);
    // R3
    phase_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tog && edge_cnt != '0) |-> (since_tog >= 2'd1));
    // R4
    lead_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tog && edge_cnt == '0) |-> (since_sel >= 2'd1));
    // R2
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (sck_act == 1'b0 && ss_n_r == 2'b11));
    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && ss_n_r != 2'b11) |=> $stable(ss_n_r) || (ss_n_r == 2'b11));
endmodule

// File: tb/spi_tsel_master_tb.sv
`timescale 1ns/1ps
module spi_tsel_master_tb_top;
    localparam int W = 8;
    localparam int LIMIT = 150000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 1'b0, sel_idx_i = 1'b0, cpol_i = 1'b0, cpha_i = 1'b0, miso_i = 1'b0;
    logic [W-1:0] tx_word_i = '0;
    logic [7:0]   div_i = 8'd2;
    logic sck_o, mosi_o, done_o;
    logic [1:0] ss_n_o;
    logic [W-1:0] rx_word_o;

    spi_tsel_master dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_word_i(tx_word_i),
        .sel_idx_i(sel_idx_i), .cpol_i(cpol_i), .cpha_i(cpha_i), .div_i(div_i),
        .miso_i(miso_i), .sck_o(sck_o), .mosi_o(mosi_o), .ss_n_o(ss_n_o),
        .rx_word_o(rx_word_o), .done_o(done_o)
    );

    always #2.5 clk = ~clk;

    int cyc = 0, n_chk = 0, n_fail = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // slave model and timing monitor, sampled at falling edges
    logic [W-1:0] slave_word = '0, s_sh, s_rx, rx_cap;
    logic m_cpha = 1'b0, prev_sck, prev_done, mosi_at_sel;
    logic [1:0] prev_ss, sel_seen;
    int edges, t_sel, t_first, t_last, t_desel, ph_min, ph_max, gap_meas, done_cnt, t_done, dbl_done;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_sck = sck_o; prev_ss = 2'b11; prev_done = 1'b0;
            edges = 0; done_cnt = 0; dbl_done = 0; t_desel = 0; gap_meas = 0;
            ph_min = 1000; ph_max = 0; s_rx = '0; s_sh = '0; rx_cap = '0;
        end else begin
            if (prev_ss == 2'b11 && ss_n_o != 2'b11) begin
                gap_meas = cyc - t_desel; t_sel = cyc; edges = 0;
                ph_min = 1000; ph_max = 0; mosi_at_sel = mosi_o;
                sel_seen = ss_n_o; s_sh = slave_word; s_rx = '0;
                if (!m_cpha) begin miso_i = s_sh[W-1]; s_sh = s_sh << 1; end
            end
            if (sck_o != prev_sck && ss_n_o != 2'b11) begin
                edges++;
                if (edges == 1) t_first = cyc;
                else begin
                    if (cyc - t_last < ph_min) ph_min = cyc - t_last;
                    if (cyc - t_last > ph_max) ph_max = cyc - t_last;
                end
                t_last = cyc;
                if (m_cpha == edges[0]) begin
                    if (!(m_cpha == 1'b0 && edges == 2*W)) begin
                        miso_i = s_sh[W-1]; s_sh = s_sh << 1;
                    end
                end else s_rx = {s_rx[W-2:0], mosi_o};
            end
            if (prev_ss != 2'b11 && ss_n_o == 2'b11) t_desel = cyc;
            if (done_o) begin
                done_cnt++; t_done = cyc; rx_cap = rx_word_o;
                if (prev_done) dbl_done++;
            end
            prev_sck = sck_o; prev_ss = ss_n_o; prev_done = done_o;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_done(input int target);
        while (done_cnt < target && cyc < LIMIT) @(negedge clk);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(ss_n_o == 2'b11, "R1", "selects in reset", ss_n_o, 3);
        chk(sck_o == cpol_i, "R1", "sck in reset", sck_o, cpol_i);
        chk(done_o == 1'b0 && mosi_o == 1'b0, "R1", "done/mosi in reset", done_o, 0);
    endtask

    task automatic test_idle_level();
        @(negedge clk); cpol_i = 1'b1;
        @(negedge clk);
        chk(sck_o == 1'b1, "R2", "idle level cpol=1", sck_o, 1);
        cpol_i = 1'b0;
        @(negedge clk);
        chk(sck_o == 1'b0, "R2", "idle level cpol=0", sck_o, 0);
    endtask

    task automatic run_xfer(input logic [W-1:0] tx, input logic [W-1:0] sw,
                            input logic sel, input logic cpol, input logic cpha,
                            input int div);
        int d0, half;
        half = (div < 2) ? 2 : div;
        @(negedge clk);
        tx_word_i = tx; slave_word = sw; sel_idx_i = sel; cpol_i = cpol;
        cpha_i = cpha; div_i = 8'(div); m_cpha = cpha; d0 = done_cnt;
        start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        wait_done(d0 + 1);
        chk(rx_cap == sw, "R7", "received word", rx_cap, sw);
        chk(s_rx == tx, "R7", "word seen by slave", s_rx, tx);
        if (!cpha) chk(mosi_at_sel == tx[W-1], "R7", "MSB ready at select", mosi_at_sel, tx[W-1]);
        chk(edges == 2*W, "R3", "edge count", edges, 2*W);
        chk(ph_min == half && ph_max == half, "R3", "half-phase length", ph_max, half);
        chk(t_first - t_sel == 2, "R4", "lead cycles", t_first - t_sel, 2);
        chk(t_desel - t_last == 2, "R5", "lag cycles", t_desel - t_last, 2);
        chk(t_done == t_desel && dbl_done == 0, "R9", "done with deselect", t_done, t_desel);
        chk(sel_seen == (sel ? 2'b01 : 2'b10), "R8", "select line", sel_seen, sel ? 1 : 2);
        @(negedge clk);
        chk(sck_o == cpol, "R2", "level after transfer", sck_o, cpol);
        chk(rx_word_o == sw, "R9", "word held after done", rx_word_o, sw);
    endtask

    task automatic test_gap();
        int d0;
        @(negedge clk);
        tx_word_i = 8'h5A; slave_word = 8'hC3; sel_idx_i = 1'b0; cpol_i = 1'b0;
        cpha_i = 1'b0; div_i = 8'd2; m_cpha = 1'b0; d0 = done_cnt;
        start_i = 1'b1;
        wait_done(d0 + 1);
        while (ss_n_o == 2'b11 && cyc < LIMIT) @(negedge clk);
        start_i = 1'b0;
        wait_done(d0 + 2);
        chk(gap_meas == 3, "R6", "select high gap", gap_meas, 3);
        chk(s_rx == 8'h5A && rx_cap == 8'hC3, "R6", "second word", rx_cap, 8'hC3);
    endtask

    task automatic test_busy_ignore();
        int d0;
        @(negedge clk);
        tx_word_i = 8'h96; slave_word = 8'h2D; sel_idx_i = 1'b1; cpol_i = 1'b1;
        cpha_i = 1'b1; div_i = 8'd3; m_cpha = 1'b1; d0 = done_cnt;
        start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (20) @(negedge clk);
        tx_word_i = 8'h00; sel_idx_i = 1'b0; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        wait_done(d0 + 1);
        chk(s_rx == 8'h96, "R10", "word unchanged by late start", s_rx, 8'h96);
        repeat (12) @(negedge clk);
        chk(done_cnt == d0 + 1, "R10", "no extra done", done_cnt, d0 + 1);
        chk(ss_n_o == 2'b11, "R10", "no extra select", ss_n_o, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_idle_level();
        run_xfer(8'hA5, 8'h3C, 1'b0, 1'b0, 1'b0, 2);
        run_xfer(8'hFF, 8'h00, 1'b1, 1'b0, 1'b1, 4);
        run_xfer(8'h00, 8'hFF, 1'b0, 1'b1, 1'b0, 0);
        run_xfer(8'h81, 8'h7E, 1'b1, 1'b1, 1'b1, 5);
        run_xfer(8'h3C, 8'hA5, 1'b0, 1'b0, 1'b1, 1);
        test_gap();
        test_busy_ignore();
        if (cyc >= LIMIT) chk(1'b0, "R3", "run hung", cyc, LIMIT);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(LIMIT * 5 + 1000);
        n_chk++; n_fail++;
        $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, LIMIT);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule